// File: doc/BRIEF.md
# Circular and Bit-Reversed Data Address Generator

This block supplies data memory addresses to a signal-processing datapath. It keeps a bank of pointer register sets. Each set has four registers: a current index, a step (modify) value, a buffer length and a buffer base. On each request the caller selects a set and chooses the step source: the set's modify register or an immediate offset supplied with the request. It also chooses between two update styles. In pre-modify the address is the index plus the step and the index is left alone. In post-modify the current index is the address and the stepped value becomes the new index.

A non-zero length turns the set into a circular buffer that may start at any base address, with no alignment or power-of-two rule. A stepped index that leaves the window [base, base+length) is folded back by one length in either direction. A length of zero gives a plain linear pointer. A bit-reverse option mirrors the outgoing address bit for bit, for FFT-style reordered access. The address and the index value for the coming cycle are produced combinationally in the request cycle, and the index register takes its new value at the clock edge. A single write port loads any register of any set. Writing a base also loads that set's index.

Top module: `dag_addr_gen`

## Requirements
- R1: After reset every register of every set reads as zero, so any request gives address 0 and next index 0.
- R2: A pre-modify request (req_pre=1) outputs index+step as the address, and the set's index is unchanged after the edge.
- R3: A post-modify request (req_pre=0) outputs the current index as the address, and the index holds the stepped (and possibly wrapped) value after the edge. idx_next shows that value during the request.
- R4: The step is req_imm when req_use_imm=1, otherwise the selected set's modify register; both are two's complement.
- R5: With length zero, post-modify stores index+step modulo 2^AW with no wrap.
- R6: With length non-zero and a non-negative step, a stepped index at or above base+length has length subtracted.
- R7: With length non-zero and a negative step, a stepped index below base has length added.
- R8: The window may start at any base value; wrap is computed against base, not against an aligned boundary.
- R9: With req_bitrev=1, addr_out bit i equals the unreversed address bit AW-1-i.
- R10: wr_sel encodes 0 = index, 1 = modify, 2 = length, 3 = base. A base write also loads the index with the same value.
- R11: A write to the index or base of a set overrides a post-modify update of that set in the same cycle. Writes to modify or length do not block the update.
- R12: Sets are independent: a request or write on one set leaves every other set's registers unchanged.
- R13: When req_valid is low or the request is pre-modify, idx_next equals the selected set's current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address request this cycle |
| req_set | input | SW | Pointer set used by the request |
| req_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| req_use_imm | input | 1 | 1 = step from req_imm, 0 = from modify register |
| req_imm | input | AW | Immediate step, two's complement |
| req_bitrev | input | 1 | Mirror the output address bits |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | SW | Set addressed by the write |
| wr_sel | input | 2 | Register select: 0 index, 1 modify, 2 length, 3 base |
| wr_data | input | AW | Write value |
| addr_out | output | AW | Generated address |
| idx_next | output | AW | Index the selected set holds after this edge |

## Verification
The window property assumes three things about a circular request: the selected index already lies inside [base, base+length), the step magnitude is no larger than the length, and base+length does not overflow AW bits. A single fold can only restore the window under those conditions. The random stimulus keeps to them. It programs each set with a small base, a length of 1 to 64 and an index drawn from inside the window. It draws modify and immediate values from [-length, length], and reloads index and base together. Only the directed corner cases for linear mode and write collisions step outside a window, and the property is not armed for them.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [1:0] {
        SEL_INDEX  = 2'd0,
        SEL_MODIFY = 2'd1,
        SEL_LENGTH = 2'd2,
        SEL_BASE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/dag_regfile.sv
module dag_regfile #(
    parameter int AW    = 32,
    parameter int NSETS = 8,
    localparam int SW   = $clog2(NSETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     rd_set,
    output logic [AW-1:0]     rd_idx,
    output logic [AW-1:0]     rd_mod,
    output logic [AW-1:0]     rd_len,
    output logic [AW-1:0]     rd_base,
    input  logic              upd_en,
    input  logic [SW-1:0]     upd_set,
    input  logic [AW-1:0]     upd_val,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_set,
    input  dag_pkg::reg_sel_e wr_sel,
    input  logic [AW-1:0]     wr_data
);
    import dag_pkg::*;

    logic [AW-1:0] idx_a  [NSETS];
    logic [AW-1:0] mod_a  [NSETS];
    logic [AW-1:0] len_a  [NSETS];
    logic [AW-1:0] base_a [NSETS];

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        logic [AW-1:0] idx_q, mod_q, len_q, base_q;
        logic          wr_hit, up_hit, idx_claimed;

        assign wr_hit      = wr_en  && (wr_set  == SW'(g));
        assign up_hit      = upd_en && (upd_set == SW'(g));
        // index or base write takes the index port this cycle
        assign idx_claimed = wr_hit && ((wr_sel == SEL_INDEX) || (wr_sel == SEL_BASE));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q  <= '0;
                mod_q  <= '0;
                len_q  <= '0;
                base_q <= '0;
            end else begin
                if (wr_hit) begin
                    unique case (wr_sel)
                        SEL_INDEX:  idx_q <= wr_data;
                        SEL_MODIFY: mod_q <= wr_data;
                        SEL_LENGTH: len_q <= wr_data;
                        SEL_BASE: begin
                            base_q <= wr_data;
                            idx_q  <= wr_data;
                        end
                    endcase
                end
                if (up_hit && !idx_claimed) begin
                    idx_q <= upd_val;
                end
            end
        end

        assign idx_a[g]  = idx_q;
        assign mod_a[g]  = mod_q;
        assign len_a[g]  = len_q;
        assign base_a[g] = base_q;
    end

    assign rd_idx  = idx_a[rd_set];
    assign rd_mod  = mod_a[rd_set];
    assign rd_len  = len_a[rd_set];
    assign rd_base = base_a[rd_set];

endmodule

// File: rtl/dag_modulo.sv
module dag_modulo #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] sum,
    output logic [AW-1:0] wrapped
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] s_ext, base_ext, end_ext;
    logic                 step_neg;

    assign step_neg = step[AW-1];
    assign sum      = cur_idx + step;
    // widened signed copies keep compares correct across 0 and 2^AW
    assign s_ext    = $signed({2'b00, cur_idx}) + $signed({{2{step[AW-1]}}, step});
    assign base_ext = $signed({2'b00, base});
    assign end_ext  = $signed({2'b00, base}) + $signed({2'b00, len});

    always_comb begin
        wrapped = sum;
        if (len != '0) begin
            if (!step_neg && (s_ext >= end_ext)) begin
                wrapped = sum - len;
            end else if (step_neg && (s_ext < base_ext)) begin
                wrapped = sum + len;
            end
        end
    end

endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign dout[i] = din[AW-1-i];
    end
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen #(
    parameter int AW    = 32,
    parameter int NSETS = 8,
    localparam int SW   = $clog2(NSETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [SW-1:0] req_set,
    input  logic          req_pre,
    input  logic          req_use_imm,
    input  logic [AW-1:0] req_imm,
    input  logic          req_bitrev,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_set,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] addr_out,
    output logic [AW-1:0] idx_next
);
    import dag_pkg::*;

    logic [AW-1:0] cur_idx, cur_mod, cur_len, cur_base;
    logic [AW-1:0] mod_sel, sum_addr, wrap_idx, raw_addr, rev_addr;
    logic          post_upd;
    reg_sel_e      wr_sel_e;

    assign wr_sel_e = reg_sel_e'(wr_sel);
    assign post_upd = req_valid && !req_pre;

    dag_regfile #(.AW(AW), .NSETS(NSETS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (req_set),
        .rd_idx  (cur_idx),
        .rd_mod  (cur_mod),
        .rd_len  (cur_len),
        .rd_base (cur_base),
        .upd_en  (post_upd),
        .upd_set (req_set),
        .upd_val (wrap_idx),
        .wr_en   (wr_en),
        .wr_set  (wr_set),
        .wr_sel  (wr_sel_e),
        .wr_data (wr_data)
    );

    assign mod_sel = req_use_imm ? req_imm : cur_mod;

    dag_modulo #(.AW(AW)) u_mod (
        .cur_idx (cur_idx),
        .step    (mod_sel),
        .len     (cur_len),
        .base    (cur_base),
        .sum     (sum_addr),
        .wrapped (wrap_idx)
    );

    assign raw_addr = req_pre ? sum_addr : cur_idx;

    dag_bitrev #(.AW(AW)) u_rev (
        .din  (raw_addr),
        .dout (rev_addr)
    );

    assign addr_out = req_bitrev ? rev_addr : raw_addr;
    assign idx_next = post_upd ? wrap_idx : cur_idx;

endmodule

// File: rtl/dag_addr_gen_chk.sv
module dag_addr_gen_chk #(
    parameter int AW    = 32,
    parameter int NSETS = 8,
    localparam int SW   = $clog2(NSETS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [SW-1:0] req_set,
    input logic          req_pre,
    input logic          req_use_imm,
    input logic [AW-1:0] req_imm,
    input logic          req_bitrev,
    input logic          wr_en,
    input logic [SW-1:0] wr_set,
    input logic [1:0]    wr_sel,
    input logic [AW-1:0] wr_data,
    input logic [AW-1:0] addr_out,
    input logic [AW-1:0] idx_next,
    input logic [AW-1:0] cur_idx,
    input logic [AW-1:0] cur_len,
    input logic [AW-1:0] cur_base,
    input logic [AW-1:0] mod_sel,
    input logic [AW-1:0] raw_addr
);
    logic [AW:0]   c_end;
    logic [AW-1:0] c_mag;
    logic          in_win;

    assign c_end  = {1'b0, cur_base} + {1'b0, cur_len};
    assign c_mag  = mod_sel[AW-1] ? (~mod_sel + 1'b1) : mod_sel;
    assign in_win = (cur_len != '0) && (cur_idx >= cur_base) && ({1'b0, cur_idx} < c_end)
                    && (c_mag <= cur_len) && !c_end[AW];

    a_r3_post_addr_is_index: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_pre && !req_bitrev) |-> (addr_out == cur_idx));

    a_r3_index_takes_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_pre && !wr_en) |=>
        ((req_set != $past(req_set)) || (cur_idx == $past(idx_next))));

    a_r2_pre_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pre && !wr_en) |=>
        ((req_set != $past(req_set)) || (cur_idx == $past(cur_idx))));

    a_r4_imm_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pre && req_use_imm && !req_bitrev) |-> (addr_out == cur_idx + req_imm));

    a_r6_r7_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_pre && in_win) |->
        ((idx_next >= cur_base) && ({1'b0, idx_next} < c_end)));

    a_r9_bitrev_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bitrev) |->
        (($countones(addr_out) == $countones(raw_addr)) && (addr_out[0] == raw_addr[AW-1])));

    a_r10_base_loads_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd3)) |=>
        ((req_set != $past(wr_set)) || (cur_idx == $past(wr_data))));

endmodule

bind dag_addr_gen dag_addr_gen_chk #(.AW(AW), .NSETS(NSETS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_set     (req_set),
    .req_pre     (req_pre),
    .req_use_imm (req_use_imm),
    .req_imm     (req_imm),
    .req_bitrev  (req_bitrev),
    .wr_en       (wr_en),
    .wr_set      (wr_set),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .addr_out    (addr_out),
    .idx_next    (idx_next),
    .cur_idx     (cur_idx),
    .cur_len     (cur_len),
    .cur_base    (cur_base),
    .mod_sel     (mod_sel),
    .raw_addr    (raw_addr)
);

// File: tb/sim_dag_addr_gen.sv
`timescale 1ns/1ps
module sim_dag_addr_gen;
    localparam int AW = 32;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_pre = 1'b0, req_use_imm = 1'b0, req_bitrev = 1'b0;
    logic [2:0]    req_set = '0, wr_set = '0;
    logic [AW-1:0] req_imm = '0, wr_data = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [AW-1:0] addr_out, idx_next;

    logic [AW-1:0] mI [NS];
    logic [AW-1:0] mM [NS];
    logic [AW-1:0] mL [NS];
    logic [AW-1:0] mB [NS];

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dag_addr_gen #(.AW(AW), .NSETS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .req_pre(req_pre), .req_use_imm(req_use_imm), .req_imm(req_imm),
        .req_bitrev(req_bitrev), .wr_en(wr_en), .wr_set(wr_set), .wr_sel(wr_sel),
        .wr_data(wr_data), .addr_out(addr_out), .idx_next(idx_next)
    );

    function automatic logic [AW-1:0] f_rev(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    function automatic logic [AW-1:0] f_step(input logic [AW-1:0] idx, input logic [AW-1:0] st,
                                             input logic [AW-1:0] len, input logic [AW-1:0] base);
        longint s;
        s = longint'(idx) + longint'($signed(st));
        if (len != 0) begin
            if (!st[AW-1] && s >= longint'(base) + longint'(len)) s = s - longint'(len);
            else if (st[AW-1] && s < longint'(base)) s = s + longint'(len);
        end
        return s[AW-1:0];
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input int s, input int sel, input logic [AW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_set = 3'(s); wr_sel = 2'(sel); wr_data = d;
        @(posedge clk);
        case (sel)
            0: mI[s] = d;
            1: mM[s] = d;
            2: mL[s] = d;
            default: begin mB[s] = d; mI[s] = d; end
        endcase
        #1 wr_en = 1'b0;
    endtask

    task automatic do_req(input string tag, input int s, input bit pre, input bit ui,
                          input logic [AW-1:0] imm, input bit br);
        logic [AW-1:0] st, raw, expn;
        @(negedge clk);
        req_valid = 1'b1; req_set = 3'(s); req_pre = pre; req_use_imm = ui;
        req_imm = imm; req_bitrev = br;
        st   = ui ? imm : mM[s];
        raw  = pre ? mI[s] + st : mI[s];
        expn = pre ? mI[s] : f_step(mI[s], st, mL[s], mB[s]);
        #2;
        check(tag, addr_out, br ? f_rev(raw) : raw);
        check(tag, idx_next, expn);
        @(posedge clk);
        mI[s] = expn;
        #1 req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int s = 0; s < NS; s++) begin mI[s] = 0; mM[s] = 0; mL[s] = 0; mB[s] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: zero state on every set, using the modify register as step
        for (int s = 0; s < NS; s++) do_req("R1", s, 1'b0, 1'b0, '0, 1'b0);

        // R8 R6: window at base 13, length 10
        do_wr(1, 2, 32'd10);
        do_wr(1, 3, 32'd13);
        do_wr(1, 1, 32'd5);
        do_wr(1, 0, 32'd20);
        do_req("R6", 1, 1'b0, 1'b0, '0, 1'b0);            // 20+5 -> 15
        do_req("R12", 0, 1'b1, 1'b1, '0, 1'b0);           // set 0 untouched
        do_req("R13", 1, 1'b1, 1'b1, '0, 1'b0);           // reads 15
        // R7: negative immediate step below base
        do_wr(1, 0, 32'd14);
        do_req("R7", 1, 1'b0, 1'b1, -32'sd3, 1'b0);       // 11 -> 21
        do_req("R7", 1, 1'b1, 1'b1, '0, 1'b0);
        // R2: pre-modify leaves index
        do_req("R2", 1, 1'b1, 1'b0, '0, 1'b0);            // 21+5=26, no wrap
        do_req("R2", 1, 1'b1, 1'b1, '0, 1'b0);            // still 21
        // R4: immediate overrides modify register
        do_req("R4", 1, 1'b1, 1'b1, 32'd100, 1'b0);
        // R5: linear pointer wraps modulo 2^AW
        do_wr(7, 0, 32'hFFFF_FFF0);
        do_req("R5", 7, 1'b0, 1'b1, 32'h20, 1'b0);
        do_req("R5", 7, 1'b1, 1'b1, '0, 1'b0);            // expect 0x10
        // R9: bit reverse
        do_wr(4, 0, 32'h0000_0001);
        do_req("R9", 4, 1'b1, 1'b1, '0, 1'b1);            // 0x80000000
        do_req("R9", 4, 1'b1, 1'b1, 32'h0000_0002, 1'b1);
        // R10: base write loads index
        do_wr(3, 3, 32'd100);
        do_req("R10", 3, 1'b1, 1'b1, '0, 1'b0);
        // R11: index write wins over same-cycle post update
        do_wr(2, 1, 32'd7);
        @(negedge clk);
        req_valid = 1'b1; req_set = 3'd2; req_pre = 1'b0; req_use_imm = 1'b0; req_bitrev = 1'b0;
        wr_en = 1'b1; wr_set = 3'd2; wr_sel = 2'd0; wr_data = 32'd555;
        @(posedge clk);
        mI[2] = 32'd555;
        #1 begin req_valid = 1'b0; wr_en = 1'b0; end
        do_req("R11", 2, 1'b1, 1'b1, '0, 1'b0);
        // R11: modify write does not block the update
        @(negedge clk);
        req_valid = 1'b1; req_set = 3'd2; req_pre = 1'b0; req_use_imm = 1'b1; req_imm = 32'd3;
        wr_en = 1'b1; wr_set = 3'd2; wr_sel = 2'd1; wr_data = 32'd9;
        @(posedge clk);
        mI[2] = 32'd558; mM[2] = 32'd9;
        #1 begin req_valid = 1'b0; wr_en = 1'b0; end
        do_req("R11", 2, 1'b1, 1'b0, '0, 1'b0);           // 558+9

        // random windows: index inside, step magnitude within length
        for (int s = 0; s < NS; s++) begin
            int unsigned ln;
            ln = 1 + ($urandom % 64);
            do_wr(s, 2, ln);
            do_wr(s, 3, $urandom % 1000);
            do_wr(s, 0, mB[s] + ($urandom % ln));
            do_wr(s, 1, 32'($signed(($urandom % (2 * ln + 1))) - $signed(ln)));
        end
        for (int n = 0; n < 400; n++) begin
            int s;
            bit pre, ui, br;
            logic [AW-1:0] imm;
            s   = $urandom % NS;
            pre = $urandom % 2;
            ui  = $urandom % 2;
            br  = ($urandom % 8) == 0;
            imm = 32'($signed(($urandom % (2 * mL[s] + 1))) - $signed(mL[s]));
            if (($urandom % 50) == 0) do_wr(s, 3, $urandom % 1000);
            do_req(pre ? "R2" : "R3", s, pre, ui, imm, br);
        end
        finish_run();
    end
endmodule